// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block lets a clocked host reach an asynchronous static RAM of 16K words by 4 bits. The host raises a request carrying a read/write flag, a word address and, for writes, a data nibble. The controller turns it into the strobe sequence the RAM needs: two active-low selects, an active-low output enable and an active-low write enable. Every phase lasts a whole number of clock cycles, derived from the RAM's nanosecond timings and the clock period.

Reads hold the address, both selects and the output enable low until the slowest of the cycle, address-access, select-access and enable-to-data times has passed. The returned nibble is sampled on the last strobe cycle. Writes first spend a turnaround window with the RAM selected but silent, so that a device still releasing the bus after an earlier read has let go. Then write enable pulses low while data is driven, and data stays driven one cycle after write enable rises. Between accesses both selects are high, so the RAM sits in its standby state.

The pad-level tristate buffer lives outside this block. The controller provides the outgoing nibble, a drive-enable flag and an input for the nibble the RAM returns.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, both selects, output enable and write enable are high, the drive-enable flag is low and the acknowledge is low.
- R2: Whenever no access is in progress, both selects are high and the bus is not driven. In particular, the acknowledge cycle has both selects high and drive-enable low.
- R3: A request is taken only when the controller is idle. A request raised while an access is under way starts no access and changes no RAM word.
- R4: A read holds both selects low, output enable low and write enable high for RD = ceil(max(tRC, tAA, tACS, tOE) / clock period) consecutive cycles (9 at 85/85/85/55 ns and a 10 ns clock).
- R5: The read nibble is sampled on the last read strobe cycle and appears on the host read-data port together with the acknowledge. It keeps that value until the next read completes.
- R6: A write begins with TA = ceil(tHZ / clock period) cycles (3 at 30 ns) in which both selects are low, output enable and write enable are high, and the controller does not drive the bus.
- R7: After the turnaround, write enable is low for WP = ceil(tWP / clock period) cycles (5 at 50 ns), with the data driven, both selects low and output enable high.
- R8: Data is still driven, with the selects low, for exactly one cycle after write enable rises. The RAM stores the driven nibble at that rising edge.
- R9: The acknowledge is a one-cycle pulse. It is high in cycle RD+1 after the accepting edge for a read and in cycle TA+WP+2 for a write, counting the first strobe cycle as cycle 1.
- R10: The address changes only on the edge where the selects fall and stays unchanged while they are low.
- R11: The controller never enables its drivers while output enable is low. It never drives in a cycle in which the RAM, still within tHZ of its last read, may be driving.
- R12: The address presented to the RAM equals the host address captured at the accepting edge. Word n of the RAM is host address n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, taken when idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write nibble |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Last read nibble |
| ram_addr | output | ADDR_W | RAM address lines |
| ram_cs1_n | output | 1 | First select, active low |
| ram_cs2_n | output | 1 | Second select, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_dq_o | output | DATA_W | Nibble to the pad buffer |
| ram_dq_oe | output | 1 | Pad buffer drive enable |
| ram_dq_i | input | DATA_W | Nibble from the pad buffer |

## Verification
The bench builds the controller with a 6-bit address (64 words), a 4-bit word, a 10 ns clock and the 85 ns timing set, which gives 9 read cycles, 3 turnaround cycles and a 5-cycle write pulse. The small address space allows every word to be written and then read back. A pseudo-random mix of accesses follows, each issued in the cycle right after the previous acknowledge. This reaches the tightest read-to-write turnaround, which the cycle-level RAM model checks for drive overlap. The model returns inverted data until tAA has elapsed, so sampling one cycle early shows up as wrong data.

// File: rtl/sram_async_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_async_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_READ   = 3'd1,
        PH_TURN   = 3'd2,
        PH_WPULSE = 3'd3,
        PH_WHOLD  = 3'd4
    } phase_e;

    typedef struct packed {
        logic cs1_n;
        logic cs2_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b, input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic strobe_t strobes_for(input phase_e ph);
        strobe_t s;
        s.cs1_n = (ph == PH_IDLE);
        s.cs2_n = (ph == PH_IDLE);
        s.oe_n  = (ph != PH_READ);
        s.we_n  = (ph != PH_WPULSE);
        s.drive = (ph == PH_WPULSE) || (ph == PH_WHOLD);
        return s;
    endfunction

endpackage

// File: rtl/sram_async_ctrl_seq.sv
`timescale 1ns/1ps
module sram_async_ctrl_seq
    import sram_async_ctrl_pkg::*;
#(
    parameter int unsigned RD_CYC = 9,
    parameter int unsigned TA_CYC = 3,
    parameter int unsigned WP_CYC = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    start_we,
    output phase_e  phase,
    output logic    idle,
    output logic    fin,
    output strobe_t pins
);
    localparam int unsigned CNT_MAX = max3(RD_CYC, TA_CYC, WP_CYC);
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] TA_LD = CNT_W'(TA_CYC - 1);
    localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);

    phase_e ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic cnt_zero;

    assign cnt_zero = (cnt_q == '0);
    assign phase    = ph_q;
    assign idle     = (ph_q == PH_IDLE);

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        fin   = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (start) begin
                    ph_d  = start_we ? PH_TURN : PH_READ;
                    cnt_d = start_we ? TA_LD : RD_LD;
                end
            end
            PH_READ: begin
                if (cnt_zero) begin
                    ph_d = PH_IDLE;
                    fin  = 1'b1;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            PH_TURN: begin
                if (cnt_zero) begin
                    ph_d  = PH_WPULSE;
                    cnt_d = WP_LD;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            PH_WPULSE: begin
                if (cnt_zero) begin
                    ph_d = PH_WHOLD;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            PH_WHOLD: begin
                ph_d = PH_IDLE;
                fin  = 1'b1;
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            pins  <= strobes_for(PH_IDLE);
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            pins  <= strobes_for(ph_d);
        end
    end
endmodule

// File: rtl/sram_async_ctrl_cmd.sv
`timescale 1ns/1ps
module sram_async_ctrl_cmd #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    cmd_t cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (start) begin
            cmd_q <= '{addr: addr, data: wdata};
        end
    end

    assign ram_addr = cmd_q.addr;
    assign ram_dq_o = cmd_q.data;
endmodule

// File: rtl/sram_async_ctrl_rdcap.sv
`timescale 1ns/1ps
module sram_async_ctrl_rdcap #(
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fin,
    input  logic              is_read,
    input  logic [DATA_W-1:0] dq_i,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack <= fin;
            if (fin && is_read) begin
                rdata <= dq_i;
            end
        end
    end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_async_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned DATA_W   = 4,
    parameter int unsigned CLK_NS   = 10,
    parameter int unsigned T_RC_NS  = 85,
    parameter int unsigned T_AA_NS  = 85,
    parameter int unsigned T_ACS_NS = 85,
    parameter int unsigned T_OE_NS  = 55,
    parameter int unsigned T_HZ_NS  = 30,
    parameter int unsigned T_WP_NS  = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs1_n,
    output logic              ram_cs2_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_dq_o,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_i
);
    localparam int unsigned RD_CYC =
        ns_to_cycles(max3(T_RC_NS, T_AA_NS, max3(T_ACS_NS, T_OE_NS, 0)), CLK_NS);
    localparam int unsigned TA_CYC = ns_to_cycles(T_HZ_NS, CLK_NS);
    localparam int unsigned WP_CYC = ns_to_cycles(T_WP_NS, CLK_NS);

    phase_e  phase;
    logic    idle;
    logic    fin;
    logic    start;
    strobe_t pins;

    assign start = host_req && idle;

    sram_async_ctrl_seq #(
        .RD_CYC(RD_CYC),
        .TA_CYC(TA_CYC),
        .WP_CYC(WP_CYC)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .start_we (host_we),
        .phase    (phase),
        .idle     (idle),
        .fin      (fin),
        .pins     (pins)
    );

    sram_async_ctrl_cmd #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) cmd_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .ram_addr (ram_addr),
        .ram_dq_o (ram_dq_o)
    );

    sram_async_ctrl_rdcap #(
        .DATA_W(DATA_W)
    ) rdcap_i (
        .clk     (clk),
        .rst     (rst),
        .fin     (fin),
        .is_read (phase == PH_READ),
        .dq_i    (ram_dq_i),
        .ack     (host_ack),
        .rdata   (host_rdata)
    );

    assign ram_cs1_n = pins.cs1_n;
    assign ram_cs2_n = pins.cs2_n;
    assign ram_oe_n  = pins.oe_n;
    assign ram_we_n  = pins.we_n;
    assign ram_dq_oe = pins.drive;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned RD_CYC = 9,
    parameter int unsigned TA_CYC = 3,
    parameter int unsigned WP_CYC = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              host_ack,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_cs1_n,
    input logic              ram_cs2_n,
    input logic              ram_oe_n,
    input logic              ram_we_n,
    input logic              ram_dq_oe
);
    logic [15:0] rd_cnt, ta_cnt, wp_cnt;
    logic sel;

    assign sel = !ram_cs1_n && !ram_cs2_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_cnt <= '0;
            ta_cnt <= '0;
            wp_cnt <= '0;
        end else begin
            rd_cnt <= (!ram_oe_n) ? rd_cnt + 16'd1 : 16'd0;
            ta_cnt <= (sel && ram_oe_n && ram_we_n && !ram_dq_oe) ? ta_cnt + 16'd1 :
                      (sel ? ta_cnt : 16'd0);
            wp_cnt <= (!ram_we_n) ? wp_cnt + 16'd1 : 16'd0;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (ram_cs1_n && ram_cs2_n && ram_oe_n && ram_we_n && !ram_dq_oe && !host_ack));

    assert_ack_deselected_R2: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> (ram_cs1_n && ram_cs2_n && !ram_dq_oe));

    assert_read_strobes_R4: assert property (@(posedge clk) disable iff (rst)
        !ram_oe_n |-> (sel && ram_we_n));

    assert_read_length_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_oe_n) |-> (rd_cnt == 16'(RD_CYC)));

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ram_we_n) |-> (ta_cnt == 16'(TA_CYC)));

    assert_write_strobes_R7: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> (sel && ram_oe_n && ram_dq_oe));

    assert_write_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we_n) |-> (wp_cnt == 16'(WP_CYC)));

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_we_n) |-> (ram_dq_oe && sel));

    assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    assert_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (sel && $past(sel)) |-> $stable(ram_addr));

    assert_no_drive_on_read_R11: assert property (@(posedge clk) disable iff (rst)
        ram_dq_oe |-> ram_oe_n);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .RD_CYC(RD_CYC),
    .TA_CYC(TA_CYC),
    .WP_CYC(WP_CYC)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .host_ack  (host_ack),
    .ram_addr  (ram_addr),
    .ram_cs1_n (ram_cs1_n),
    .ram_cs2_n (ram_cs2_n),
    .ram_oe_n  (ram_oe_n),
    .ram_we_n  (ram_we_n),
    .ram_dq_oe (ram_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int DW    = 4;
    localparam int WORDS = 1 << AW;
    localparam int T_RC  = 85;
    localparam int T_AA  = 85;
    localparam int T_OE  = 55;
    localparam int T_HZ  = 30;
    localparam int T_WP  = 50;
    localparam int EXP_RD = (T_RC + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_TA = (T_HZ + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_WP = (T_WP + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int EXP_RLAT = EXP_RD + 1;
    localparam int EXP_WLAT = EXP_TA + EXP_WP + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_req = 1'b0;
    logic host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic host_ack;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] ram_addr;
    logic ram_cs1_n, ram_cs2_n, ram_oe_n, ram_we_n, ram_dq_oe;
    logic [DW-1:0] ram_dq_o;
    logic [DW-1:0] ram_dq_i;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_async_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_PERIOD),
        .T_RC_NS(T_RC), .T_AA_NS(T_AA), .T_ACS_NS(T_AA),
        .T_OE_NS(T_OE), .T_HZ_NS(T_HZ), .T_WP_NS(T_WP)
    ) dut_i (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .ram_addr(ram_addr), .ram_cs1_n(ram_cs1_n), .ram_cs2_n(ram_cs2_n),
        .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ram_dq_o(ram_dq_o),
        .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Cycle-level RAM model, evaluated at the falling edge
    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] exp_mem [WORDS];
    int hz_cnt = 0;
    int acc_cnt = 0;
    int rd_run = 0;
    int ta_run = 0;
    int wp_run = 0;
    bit sel_prev = 0;
    bit sel_read_prev = 0;
    bit we_low_prev = 0;
    logic [AW-1:0] addr_prev = '0;
    logic [AW-1:0] cur_addr = '0;
    logic sel, sel_read, ram_drv, rd_valid;

    assign sel      = !ram_cs1_n && !ram_cs2_n;
    assign sel_read = sel && !ram_oe_n && ram_we_n;
    assign ram_drv  = sel_read || (hz_cnt != 0);
    assign rd_valid = (acc_cnt * CLK_PERIOD) >= T_AA;
    assign ram_dq_i = rd_valid ? mem[ram_addr] : ~mem[ram_addr];

    always @(negedge clk) begin
        if (!rst) begin
            if (ram_drv && ram_dq_oe) chk(0, "R11 bus contention", 1, 0);
            if (sel && sel_prev && ram_addr != addr_prev)
                chk(0, "R10 address moved while selected", int'(ram_addr), int'(addr_prev));
            if (sel && !sel_prev)
                chk(ram_addr == cur_addr, "R12 address at select", int'(ram_addr), int'(cur_addr));
            if (!ram_we_n && (!ram_oe_n || !ram_dq_oe || !sel))
                chk(0, "R7 write strobe ordering", 0, 1);
            if (sel_read) rd_run++;
            else if (rd_run != 0) begin
                chk(rd_run == EXP_RD, "R4 read strobe length", rd_run, EXP_RD);
                rd_run = 0;
            end
            if (!ram_we_n) begin
                if (!we_low_prev) chk(ta_run == EXP_TA, "R6 turnaround length", ta_run, EXP_TA);
                wp_run++;
            end else if (we_low_prev) begin
                chk(wp_run == EXP_WP, "R7 write pulse length", wp_run, EXP_WP);
                chk(ram_dq_oe && sel, "R8 data hold after write enable", int'(ram_dq_oe), 1);
                mem[ram_addr] = ram_dq_oe ? ram_dq_o : ~ram_dq_o;
                wp_run = 0;
            end
            if (sel && ram_oe_n && ram_we_n && !ram_dq_oe) ta_run++;
            else if (!sel) ta_run = 0;
            if (sel_read)
                acc_cnt = (sel_read_prev && ram_addr == addr_prev) ? acc_cnt + 1 : 1;
            else
                acc_cnt = 0;
            hz_cnt = sel_read ? EXP_TA + 1 : ((hz_cnt != 0) ? hz_cnt - 1 : 0);
            sel_prev      = sel;
            sel_read_prev = sel_read;
            we_low_prev   = !ram_we_n;
            addr_prev     = ram_addr;
        end
    end

    task automatic access(input bit w, input int a, input logic [DW-1:0] d, output int lat);
        cur_addr   = AW'(a);
        host_req   = 1'b1;
        host_we    = w;
        host_addr  = AW'(a);
        host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        lat = 1;
        while (!host_ack && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R9 watchdog: access never acknowledged", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lat;
        logic [DW-1:0] held;
        logic [15:0] lfsr;
        bit quiet;
        for (int i = 0; i < WORDS; i++) begin
            mem[i] = '0;
            exp_mem[i] = '0;
        end
        repeat (3) @(negedge clk);
        chk(ram_cs1_n && ram_cs2_n && ram_oe_n && ram_we_n, "R1 strobes in reset",
            int'({ram_cs1_n, ram_cs2_n, ram_oe_n, ram_we_n}), 15);
        chk(!ram_dq_oe && !host_ack, "R1 drive and ack in reset", int'({ram_dq_oe, host_ack}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ram_cs1_n && ram_cs2_n && !ram_dq_oe, "R2 idle after reset",
            int'({ram_cs1_n, ram_cs2_n, ram_dq_oe}), 6);

        // R12 / R9: write every word
        for (int a = 0; a < WORDS; a++) begin
            logic [DW-1:0] d;
            d = DW'(a * 7 + 5);
            access(1'b1, a, d, lat);
            exp_mem[a] = d;
            chk(lat == EXP_WLAT, "R9 write ack cycle", lat, EXP_WLAT);
            chk(ram_cs1_n && ram_cs2_n && !ram_dq_oe, "R2 deselected at ack",
                int'({ram_cs1_n, ram_cs2_n, ram_dq_oe}), 6);
        end
        // R5 / R9: read every word back, highest first
        for (int a = WORDS - 1; a >= 0; a--) begin
            access(1'b0, a, '0, lat);
            chk(lat == EXP_RLAT, "R9 read ack cycle", lat, EXP_RLAT);
            chk(host_rdata == exp_mem[a], "R5 read data", int'(host_rdata), int'(exp_mem[a]));
        end
        // Mixed back-to-back traffic (R5, R11, R12)
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            bit w;
            int a;
            logic [DW-1:0] d;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            w = lfsr[0];
            a = int'(lfsr[AW+1:2]);
            d = lfsr[15:12];
            access(w, a, d, lat);
            if (w) begin
                exp_mem[a] = d;
                chk(lat == EXP_WLAT, "R9 mixed write ack", lat, EXP_WLAT);
            end else begin
                chk(host_rdata == exp_mem[a], "R5 mixed read data", int'(host_rdata), int'(exp_mem[a]));
            end
        end
        // R5: read data held across a write
        access(1'b0, 10, '0, lat);
        held = host_rdata;
        access(1'b1, 11, ~exp_mem[11], lat);
        exp_mem[11] = ~exp_mem[11];
        chk(host_rdata == held, "R5 read data held across write", int'(host_rdata), int'(held));

        // R3: request while busy is ignored
        cur_addr   = AW'(20);
        host_req   = 1'b1;
        host_we    = 1'b1;
        host_addr  = AW'(20);
        host_wdata = 4'h9;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        repeat (3) @(negedge clk);
        host_req   = 1'b1;
        host_addr  = AW'(21);
        host_wdata = ~exp_mem[21];
        @(negedge clk);
        host_req = 1'b0;
        lat = 0;
        while (!host_ack && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        exp_mem[20] = 4'h9;
        quiet = 1;
        repeat (12) begin
            @(negedge clk);
            if (!ram_cs1_n || !ram_cs2_n || host_ack) quiet = 0;
        end
        chk(quiet, "R3 no access from busy request", int'(quiet), 1);
        access(1'b0, 21, '0, lat);
        chk(host_rdata == exp_mem[21], "R3 word untouched by busy request",
            int'(host_rdata), int'(exp_mem[21]));
        access(1'b0, 20, '0, lat);
        chk(host_rdata == 4'h9, "R3 accepted write stored", int'(host_rdata), 9);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule